// File: doc/BRIEF.md
# Serial Combination Lock Controller

The block checks a secret code that an operator types in one bit at a time. A key bit is presented on `key_bit` together with `key_valid`. The controller takes it in any cycle where `key_ready` is also high. Each bit it takes is compared with the matching bit of a stored code. After the last bit, the controller shows one of two results. If every bit matched, it raises `unlock`. If any bit was wrong, it raises `error`. A wrong bit is never revealed early. After the first mismatch the controller keeps taking bits along a separate error track, so the result only appears once the whole code has been entered.

The stored code sits in a register, not in the next-state logic. It is written through `ld_en`/`ld_code`, but only while the controller is still in its starting state, before any key bit has been taken. The result holds until reset. While the result is shown, `key_ready` stays low, so further key beats are held off and have no effect. Reset returns the controller to the starting state and clears the stored code to all zeros.

Top module: `serial_lock`

## Requirements
- R1: After reset `key_ready` is 1, `unlock` and `error` are 0, and the stored code is all zeros.
- R2: The k-th key bit taken, counting from 0, is compared with bit k of the stored code, so the first bit taken is compared with `ld_code[0]`.
- R3: If all N bits taken match, `unlock` is 1 from the cycle after the clock edge that takes the N-th bit, and `error` stays 0.
- R4: If any bit taken mismatches, `error` is 1 from the cycle after the N-th bit is taken. Before the N-th bit, both `unlock` and `error` stay 0, whatever the bits were.
- R5: Once `unlock` or `error` is 1, it holds until reset. `key_ready` is 0 during that time, and key beats offered then change nothing.
- R6: `ld_en` loads `ld_code` into the stored code only while no key bit has yet been taken since reset. At any other time the load has no effect.
- R7: If a load and the first key bit arrive in the same cycle, that first bit is compared with the old code. The new code applies to every later bit.
- R8: A key bit is taken only on a clock edge where `key_valid` and `key_ready` are both 1. In cycles with `key_valid` low, changes on `key_bit` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Request to write the stored code |
| ld_code | input | N | New code value; bit k is checked against the k-th key bit taken |
| key_valid | input | 1 | Key bit offered this cycle |
| key_bit | input | 1 | Key bit value |
| key_ready | output | 1 | Controller can take a key bit |
| unlock | output | 1 | All bits matched; held until reset |
| error | output | 1 | At least one bit mismatched; held until reset |

## Verification
The bench sweeps every 3-bit stored code against every 3-bit entry. It places idle cycles with a toggling `key_bit` between beats. A design that compared bits in the wrong order, or took bits while `key_valid` was low, would give the wrong verdict on some pairs. It also checks the outputs after the first and second beats, which catches a design that shows `error` at the first wrong bit. Separate cases try a load after the first bit, and a load in the same cycle as the first bit, to catch a code register that is not locked once entry has begun. Extra beats after the verdict check that the result neither flips nor clears.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_GOOD  = 3'd1,
    ST_BAD   = 3'd2,
    ST_OPEN  = 3'd3,
    ST_ALARM = 3'd4
  } lock_st_e;
endpackage

// File: rtl/lock_code_reg.sv
module lock_code_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [N-1:0] ld_code,
  input  logic         start_i,
  output logic [N-1:0] code_o
);
  logic [N-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                code_q <= '0;
    else if (ld_en && start_i) code_q <= ld_code;
  end

  assign code_o = code_q;

  AST_LOAD_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(code_q)); // R6
endmodule

// File: rtl/lock_match.sv
module lock_match #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  code_i,
  input  logic [IW-1:0] idx_i,
  input  logic          bit_i,
  output logic          match_o
);
  logic [N-1:0] hit;

  for (genvar k = 0; k < N; k++) begin : g_pos
    assign hit[k] = (idx_i == IW'(k)) && (code_i[k] == bit_i);
  end

  assign match_o = |hit;
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_pkg::*;
#(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid_i,
  input  logic          match_i,
  output logic [IW-1:0] idx_o,
  output logic          start_o,
  output logic          key_ready_o,
  output logic          open_o,
  output logic          alarm_o
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  lock_st_e      st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          beat, bad_now;

  assign key_ready_o = (st_q == ST_START) || (st_q == ST_GOOD) || (st_q == ST_BAD);
  assign beat        = key_valid_i && key_ready_o;
  assign bad_now     = !match_i || (st_q == ST_BAD);

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    case (st_q)
      ST_START, ST_GOOD, ST_BAD: begin
        if (beat) begin
          if (idx_q == LAST) begin
            st_n  = bad_now ? ST_ALARM : ST_OPEN;
            idx_n = '0;
          end else begin
            st_n  = bad_now ? ST_BAD : ST_GOOD;
            idx_n = idx_q + 1'b1;
          end
        end
      end
      ST_OPEN, ST_ALARM: ;
      default: begin
        st_n  = ST_START;
        idx_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_START;
      idx_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
    end
  end

  assign idx_o   = idx_q;
  assign start_o = (st_q == ST_START);
  assign open_o  = (st_q == ST_OPEN);
  assign alarm_o = (st_q == ST_ALARM);

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST); // R2
  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    open_o |=> open_o); // R5
  AST_ALARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> alarm_o); // R5
  AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && idx_q != LAST) |=> !(open_o || alarm_o)); // R4
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid_i |=> ($stable(idx_q) && $stable(st_q))); // R8
  AST_OPEN_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && idx_q == LAST && !match_i) |=> !open_o); // R3
endmodule

// File: rtl/serial_lock.sv
module serial_lock #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [N-1:0] ld_code,
  input  logic         key_valid,
  input  logic         key_bit,
  output logic         key_ready,
  output logic         unlock,
  output logic         error
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  code;
  logic [IW-1:0] idx;
  logic          in_start, match;

  lock_code_reg #(.N(N)) u_code (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_code(ld_code),
    .start_i(in_start), .code_o(code)
  );

  lock_match #(.N(N), .IW(IW)) u_match (
    .code_i(code), .idx_i(idx), .bit_i(key_bit), .match_o(match)
  );

  lock_seq #(.N(N), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_valid_i(key_valid), .match_i(match),
    .idx_o(idx), .start_o(in_start), .key_ready_o(key_ready),
    .open_o(unlock), .alarm_o(error)
  );

  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !error); // R3
endmodule

// File: tb/sim_serial_lock.sv
module sim_serial_lock;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, ld_en = 0, key_valid = 0, key_bit = 0;
  logic [N-1:0] ld_code = '0;
  logic key_ready, unlock, error;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_lock #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_code(ld_code),
    .key_valid(key_valid), .key_bit(key_bit),
    .key_ready(key_ready), .unlock(unlock), .error(error)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ld_en = 0; key_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load(logic [N-1:0] c);
    @(negedge clk); ld_en = 1; ld_code = c;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic beat(logic b, int gaps);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk); key_valid = 0; key_bit = ~b;
    end
    @(negedge clk); key_valid = 1; key_bit = b;
    @(negedge clk); key_valid = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 ready", key_ready, 1'b1);
    chk("R1 unlock", unlock, 1'b0);
    chk("R1 error", error, 1'b0);
    // R1: cleared code accepts 000
    for (int k = 0; k < N; k++) beat(1'b0, 0);
    chk("R1 zero code", unlock, 1'b1);

    // R2 R3 R4 R5 R8: every code against every entry
    for (int c = 0; c < (1 << N); c++) begin
      for (int e = 0; e < (1 << N); e++) begin
        do_reset();
        load(N'(c));
        for (int k = 0; k < N; k++) begin
          beat(e[k], (c + e + k) % 3);
          if (k < N - 1) begin
            chk("R4 no early unlock", unlock, 1'b0);
            chk("R4 no early error", error, 1'b0);
          end
        end
        chk("R3 unlock", unlock, (e == c));
        chk("R4 error", error, (e != c));
        chk("R5 ready low", key_ready, 1'b0);
        for (int k = 0; k < 2; k++) beat(~e[k], 1);
        chk("R5 unlock held", unlock, (e == c));
        chk("R5 error held", error, (e != c));
      end
    end

    // R6: load after first bit taken is ignored (code 101 kept, 010 refused)
    do_reset();
    load(3'b101);
    beat(1'b1, 0);
    load(3'b010);
    beat(1'b0, 1);
    beat(1'b1, 0);
    chk("R6 late load ignored", unlock, 1'b1);
    load(3'b111);
    do_reset();
    for (int k = 0; k < N; k++) beat(1'b0, 0);
    chk("R6 reset clears code", unlock, 1'b1);

    // R7: same-cycle load and first bit: bit0 vs old 000, later bits vs new 111
    do_reset();
    @(negedge clk);
    ld_en = 1; ld_code = 3'b111; key_valid = 1; key_bit = 1'b0;
    @(negedge clk);
    ld_en = 0; key_valid = 0;
    beat(1'b1, 0);
    beat(1'b1, 0);
    chk("R7 unlock", unlock, 1'b1);
    chk("R7 error", error, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule